// File: doc/BRIEF.md
# Saturating Accumulator with Status Control

This block is a fixed-point accumulate stage that keeps its own status word. A 32-bit product value is passed through a scaler whose shift is picked by a two-bit mode field, and the scaled copy can be added into a 32-bit accumulator. A 16-bit data operand can also be added. It first goes through an extension stage that is controlled by a sign-extension mode bit. An overflow-mode bit chooses between plain two's-complement wrap and clamping to the extreme values.

The status word holds the overflow mode, the product scale mode, the sign-extension mode, a test flag and an external flag. The external flag drives a general-purpose output pin. Status bits are changed by individual set and clear commands, by a scale-mode write, or by loading a whole status word at once. The test flag is written by three kinds of check: a bit test on the data operand, an unsigned compare of an auxiliary value against a reference value, and a normalization check on the top two accumulator bits. One command is accepted per clock, and its effect is visible after the next rising edge.

Top module: `acc_status_unit`

## Requirements
- R1: The scaled product output `pshift_o` follows `preg_i` and the scale mode `pm_o` combinationally. Mode 2'b00 passes the value unchanged. Mode 2'b01 shifts it left by 1 and mode 2'b10 shifts it left by 4, with zeros entering at the bottom. Mode 2'b11 shifts it right by 6, with copies of bit 31 entering at the top.
- R2: Command 4'd5 (add product) adds `pshift_o` into the accumulator. The product input itself is only read and is never altered.
- R3: On an add, overflow means that both addends have the same sign and the sum has the other sign. With `ovm_o`=0 the sum wraps. With `ovm_o`=1 a positive overflow gives 32'h7FFFFFFF and a negative overflow gives 32'h80000000.
- R4: Command 4'd6 adds `data_i` after sign extension when `sxm_o`=1, and after zero extension when `sxm_o`=0. Command 4'd7 always adds `data_i` zero-extended, whatever `sxm_o` holds.
- R5: Command 4'd8 sets `tc_o` to `data_i[sel_i]`.
- R6: Command 4'd9 compares `aux_i` with `ref_i` as unsigned numbers and writes the result to `tc_o`. The condition is picked by `sel_i[1:0]`: 0 is equal, 1 is aux less than ref, 2 is aux greater than ref, 3 is not equal.
- R7: Command 4'd10 sets `tc_o` to the exclusive-OR of accumulator bits 31 and 30.
- R8: After reset the accumulator is 0, `pm_o`=2'b00, `sxm_o`=1, `xf_o`=1, `ovm_o`=0 and `tc_o`=0.
- R9: Command 4'd1 sets and command 4'd2 clears one status bit, chosen by `sel_i[1:0]`: 0 is the overflow mode, 1 is the sign-extension mode, 2 is the external flag. Selector 3 leaves all status unchanged.
- R10: Command 4'd3 writes `sel_i[1:0]` into the scale mode. Command 4'd4 loads the whole status word from `data_i[5:0]`, laid out as bit 0 overflow mode, bits 2:1 scale mode, bit 3 sign-extension mode, bit 4 test flag and bit 5 external flag.
- R11: Output pin `xf_o` always shows the current external flag. It changes in the cycle after a command that writes it.
- R12: Command 4'd0 and the unused codes 4'd12 to 4'd15 leave the accumulator and all status unchanged. Command 4'd11 clears the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 4 | Command code, one per cycle |
| sel_i | input | 4 | Bit index, status bit selector, compare condition or scale mode |
| data_i | input | 16 | Data operand or status word |
| preg_i | input | 32 | Product value to be scaled |
| aux_i | input | 16 | Auxiliary value for compare |
| ref_i | input | 16 | Reference value for compare |
| pshift_o | output | 32 | Scaled copy of the product |
| acc_o | output | 32 | Accumulator |
| ovm_o | output | 1 | Overflow (saturation) mode |
| pm_o | output | 2 | Product scale mode |
| sxm_o | output | 1 | Sign-extension mode |
| tc_o | output | 1 | Test flag |
| xf_o | output | 1 | External flag pin |

## Verification
The hardest case to reach from the ports is an overflow at the exact edge of the range. The accumulator has no direct load, so it has to be brought to a value such as 32'h7FFFFFF0 or 32'h80000000 first. The bench does this by clearing the accumulator, setting scale mode 00 and adding a chosen product. It then changes the scale and overflow modes and makes a second add that crosses the limit. Every table row repeats this sequence, so wrap and clamp are both seen in each direction, and a scaled addend (left by 1) is also seen overflowing.

// File: rtl/acc_status_pkg.sv
package acc_status_pkg;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_SETB  = 4'd1,
        CMD_CLRB  = 4'd2,
        CMD_SETPM = 4'd3,
        CMD_LDST  = 4'd4,
        CMD_ADDP  = 4'd5,
        CMD_ADDD  = 4'd6,
        CMD_ADDDZ = 4'd7,
        CMD_BTST  = 4'd8,
        CMD_CMP   = 4'd9,
        CMD_NORM  = 4'd10,
        CMD_ZACC  = 4'd11
    } acc_cmd_e;

    // Packed so that a status word load maps bit for bit.
    typedef struct packed {
        logic       xf;
        logic       tc;
        logic       sxm;
        logic [1:0] pm;
        logic       ovm;
    } status_t;

    localparam status_t STATUS_RESET = '{xf: 1'b1, tc: 1'b0, sxm: 1'b1, pm: 2'b00, ovm: 1'b0};

endpackage

// File: rtl/acc_prod_scaler.sv
module acc_prod_scaler #(
    parameter int W     = 32,
    parameter int SHL_A = 1,
    parameter int SHL_B = 4,
    parameter int SHR   = 6
) (
    input  logic [W-1:0] prod_i,
    input  logic [1:0]   mode_i,
    output logic [W-1:0] scaled_o
);

    logic signed [W-1:0] prod_s;
    assign prod_s = $signed(prod_i);

    always_comb begin
        unique case (mode_i)
            2'b00:   scaled_o = prod_i;
            2'b01:   scaled_o = prod_i << SHL_A;
            2'b10:   scaled_o = prod_i << SHL_B;
            default: scaled_o = $unsigned(prod_s >>> SHR);
        endcase
    end

endmodule

// File: rtl/acc_sat_add.sv
module acc_sat_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sat_en_i,
    output logic [W-1:0] sum_o
);

    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] raw;
    logic         ovf;

    assign raw = a_i + b_i;
    assign ovf = (a_i[W-1] == b_i[W-1]) && (raw[W-1] != a_i[W-1]);

    always_comb begin
        if (ovf && sat_en_i)
            sum_o = a_i[W-1] ? NEG_MIN : POS_MAX;
        else
            sum_o = raw;
    end

endmodule

// File: rtl/acc_test_flag.sv
module acc_test_flag
    import acc_status_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int AUX_W  = 16,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input  acc_cmd_e          cmd_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [AUX_W-1:0]  aux_i,
    input  logic [AUX_W-1:0]  ref_i,
    input  logic [1:0]        acc_top_i,
    output logic              we_o,
    output logic              val_o
);

    logic cmp_hit;

    always_comb begin
        unique case (sel_i[1:0])
            2'd0:    cmp_hit = (aux_i == ref_i);
            2'd1:    cmp_hit = (aux_i <  ref_i);
            2'd2:    cmp_hit = (aux_i >  ref_i);
            default: cmp_hit = (aux_i != ref_i);
        endcase
    end

    always_comb begin
        we_o  = 1'b1;
        val_o = 1'b0;
        case (cmd_i)
            CMD_BTST: val_o = data_i[sel_i];
            CMD_CMP:  val_o = cmp_hit;
            CMD_NORM: val_o = acc_top_i[1] ^ acc_top_i[0];
            default:  we_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_status_reg.sv
module acc_status_reg
    import acc_status_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  acc_cmd_e cmd_i,
    input  logic [1:0] sel_i,
    input  logic [5:0] word_i,
    input  logic     tc_we_i,
    input  logic     tc_val_i,
    output status_t  st_o
);

    status_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (cmd_i)
            CMD_SETB, CMD_CLRB: begin
                unique case (sel_i)
                    2'd0:    st_d.ovm = (cmd_i == CMD_SETB);
                    2'd1:    st_d.sxm = (cmd_i == CMD_SETB);
                    2'd2:    st_d.xf  = (cmd_i == CMD_SETB);
                    default: st_d     = st_q;
                endcase
            end
            CMD_SETPM: st_d.pm = sel_i;
            CMD_LDST:  st_d    = status_t'(word_i);
            default:   st_d    = st_q;
        endcase
        if (tc_we_i)
            st_d.tc = tc_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= STATUS_RESET;
        else
            st_q <= st_d;
    end

    assign st_o = st_q;

endmodule

// File: rtl/acc_status_unit.sv
module acc_status_unit
    import acc_status_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int DATA_W = 16,
    parameter int AUX_W  = 16,
    parameter int SHL_A  = 1,
    parameter int SHL_B  = 4,
    parameter int SHR    = 6,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ACC_W-1:0]  preg_i,
    input  logic [AUX_W-1:0]  aux_i,
    input  logic [AUX_W-1:0]  ref_i,
    output logic [ACC_W-1:0]  pshift_o,
    output logic [ACC_W-1:0]  acc_o,
    output logic              ovm_o,
    output logic [1:0]        pm_o,
    output logic              sxm_o,
    output logic              tc_o,
    output logic              xf_o
);

    localparam int EXT_W = ACC_W - DATA_W;

    acc_cmd_e         cmd;
    status_t          st;
    logic [ACC_W-1:0] acc_q, acc_d;
    logic [ACC_W-1:0] addend, sum;
    logic [ACC_W-1:0] data_ext;
    logic             ext_sign;
    logic             tc_we, tc_val;

    assign cmd = acc_cmd_e'(cmd_i);

    acc_prod_scaler #(.W(ACC_W), .SHL_A(SHL_A), .SHL_B(SHL_B), .SHR(SHR)) u_scaler (
        .prod_i   (preg_i),
        .mode_i   (st.pm),
        .scaled_o (pshift_o)
    );

    // Extension stage: the suppress-extension add ignores the mode bit.
    assign ext_sign = st.sxm && (cmd != CMD_ADDDZ) && data_i[DATA_W-1];
    assign data_ext = {{EXT_W{ext_sign}}, data_i};

    always_comb begin
        unique case (cmd)
            CMD_ADDP: addend = pshift_o;
            default:  addend = data_ext;
        endcase
    end

    acc_sat_add #(.W(ACC_W)) u_adder (
        .a_i      (acc_q),
        .b_i      (addend),
        .sat_en_i (st.ovm),
        .sum_o    (sum)
    );

    acc_test_flag #(.DATA_W(DATA_W), .AUX_W(AUX_W), .SEL_W(SEL_W)) u_tflag (
        .cmd_i     (cmd),
        .sel_i     (sel_i),
        .data_i    (data_i),
        .aux_i     (aux_i),
        .ref_i     (ref_i),
        .acc_top_i (acc_q[ACC_W-1 -: 2]),
        .we_o      (tc_we),
        .val_o     (tc_val)
    );

    acc_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .sel_i    (sel_i[1:0]),
        .word_i   (data_i[5:0]),
        .tc_we_i  (tc_we),
        .tc_val_i (tc_val),
        .st_o     (st)
    );

    always_comb begin
        case (cmd)
            CMD_ADDP, CMD_ADDD, CMD_ADDDZ: acc_d = sum;
            CMD_ZACC:                      acc_d = '0;
            default:                       acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end

    assign acc_o = acc_q;
    assign ovm_o = st.ovm;
    assign pm_o  = st.pm;
    assign sxm_o = st.sxm;
    assign tc_o  = st.tc;
    assign xf_o  = st.xf;

endmodule

// File: rtl/acc_status_checker.sv
module acc_status_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  cmd_i,
    input logic [1:0]  sel_lo,
    input logic [31:0] preg_i,
    input logic [31:0] pshift_o,
    input logic [31:0] acc_o,
    input logic        ovm_o,
    input logic [1:0]  pm_o,
    input logic        sxm_o,
    input logic        tc_o,
    input logic        xf_o
);

    // R1: the right-shift mode replicates the sign into the top six bits
    a_r1_pm3_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_o == 2'b11) |-> (pshift_o[31:26] == {6{preg_i[31]}}));

    // R3: a clamped add of two non-negatives never turns negative
    a_r3_sat_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd5 && ovm_o && !acc_o[31] && !pshift_o[31]) |=> !acc_o[31]);

    // R3: a clamped add of two negatives stays negative
    a_r3_sat_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd5 && ovm_o && acc_o[31] && pshift_o[31]) |=> acc_o[31]);

    // R7: the normalize check reflects the top two accumulator bits
    a_r7_norm_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd10) |=> (tc_o == ($past(acc_o[31]) ^ $past(acc_o[30]))));

    // R9: setting the overflow-mode bit takes effect on the next edge
    a_r9_set_ovm: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd1 && sel_lo == 2'd0) |=> ovm_o);

    // R12: an idle command holds the accumulator and status
    a_r12_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd0) |=> ($stable(acc_o) && $stable({xf_o, tc_o, sxm_o, pm_o, ovm_o})));

endmodule

bind acc_status_unit acc_status_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd_i),
    .sel_lo   (sel_i[1:0]),
    .preg_i   (preg_i),
    .pshift_o (pshift_o),
    .acc_o    (acc_o),
    .ovm_o    (ovm_o),
    .pm_o     (pm_o),
    .sxm_o    (sxm_o),
    .tc_o     (tc_o),
    .xf_o     (xf_o)
);

// File: tb/acc_status_unit_test.sv
`timescale 1ns/1ps
module acc_status_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd_i = 4'd0;
    logic [3:0]  sel_i = 4'd0;
    logic [15:0] data_i = 16'd0;
    logic [31:0] preg_i = 32'd0;
    logic [15:0] aux_i = 16'd0;
    logic [15:0] ref_i = 16'd0;
    logic [31:0] pshift_o, acc_o;
    logic        ovm_o, sxm_o, tc_o, xf_o;
    logic [1:0]  pm_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    acc_status_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .sel_i(sel_i), .data_i(data_i),
        .preg_i(preg_i), .aux_i(aux_i), .ref_i(ref_i), .pshift_o(pshift_o),
        .acc_o(acc_o), .ovm_o(ovm_o), .pm_o(pm_o), .sxm_o(sxm_o), .tc_o(tc_o), .xf_o(xf_o)
    );

    typedef struct packed {
        logic [1:0]  pm;
        logic        ovm;
        logic [31:0] start;
        logic [31:0] prod;
        logic [31:0] scaled;
        logic [31:0] result;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{2'b00, 1'b0, 32'h0000_0000, 32'h0000_0005, 32'h0000_0005, 32'h0000_0005},
        '{2'b01, 1'b0, 32'h0000_0010, 32'h0000_0003, 32'h0000_0006, 32'h0000_0016},
        '{2'b10, 1'b0, 32'h0000_0100, 32'h0000_000F, 32'h0000_00F0, 32'h0000_01F0},
        '{2'b11, 1'b0, 32'h0000_0000, 32'hFFFF_F000, 32'hFFFF_FFC0, 32'hFFFF_FFC0},
        '{2'b00, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0001, 32'h8000_0000},
        '{2'b00, 1'b1, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF},
        '{2'b00, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000},
        '{2'b00, 1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF},
        '{2'b01, 1'b1, 32'h4000_0000, 32'h4000_0000, 32'h8000_0000, 32'hC000_0000},
        '{2'b01, 1'b1, 32'h7FFF_FFF0, 32'h0000_0010, 32'h0000_0020, 32'h7FFF_FFFF}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge; after the next falling edge the result is visible.
    task automatic issue(input logic [3:0] c, input logic [3:0] s, input logic [15:0] d);
        cmd_i  = c;
        sel_i  = s;
        data_i = d;
        @(negedge clk);
        cmd_i  = 4'd0;
    endtask

    task automatic load_acc(input logic [31:0] v);
        issue(4'd11, 4'd0, 16'd0);
        issue(4'd3, 4'd0, 16'd0);
        preg_i = v;
        issue(4'd5, 4'd0, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        chk("R8 acc", acc_o, 32'd0);
        chk("R8 status", {26'd0, xf_o, tc_o, sxm_o, pm_o, ovm_o}, 32'h28);
        // R11 pin follows the external flag after reset
        chk("R11 pin reset", {31'd0, xf_o}, 32'd1);

        // R12 idle and unused codes hold state
        issue(4'd0, 4'd2, 16'h003F);
        chk("R12 nop status", {26'd0, xf_o, tc_o, sxm_o, pm_o, ovm_o}, 32'h28);
        issue(4'd15, 4'd1, 16'hFFFF);
        chk("R12 unused status", {26'd0, xf_o, tc_o, sxm_o, pm_o, ovm_o}, 32'h28);
        chk("R12 unused acc", acc_o, 32'd0);

        // R1 R2 R3 table
        for (int i = 0; i < 10; i++) begin
            load_acc(VECS[i].start);
            chk("R2 preload", acc_o, VECS[i].start);
            issue(4'd3, {2'b00, VECS[i].pm}, 16'd0);
            issue(VECS[i].ovm ? 4'd1 : 4'd2, 4'd0, 16'd0);
            preg_i = VECS[i].prod;
            #1;
            chk("R1 scaled product", pshift_o, VECS[i].scaled);
            @(negedge clk);
            issue(4'd5, 4'd0, 16'd0);
            chk("R3 add result", acc_o, VECS[i].result);
            chk("R2 product unchanged", pshift_o, VECS[i].scaled);
        end

        // R12 clear accumulator
        issue(4'd11, 4'd0, 16'd0);
        chk("R12 clear", acc_o, 32'd0);

        // R4 extension
        issue(4'd2, 4'd0, 16'd0);
        issue(4'd1, 4'd1, 16'd0);
        issue(4'd6, 4'd0, 16'h8000);
        chk("R4 sign extend", acc_o, 32'hFFFF_8000);
        issue(4'd11, 4'd0, 16'd0);
        issue(4'd7, 4'd0, 16'h8000);
        chk("R4 suppressed extend", acc_o, 32'h0000_8000);
        issue(4'd2, 4'd1, 16'd0);
        issue(4'd11, 4'd0, 16'd0);
        issue(4'd6, 4'd0, 16'h8000);
        issue(4'd6, 4'd0, 16'h1234);
        chk("R4 zero extend", acc_o, 32'h0000_9234);

        // R5 bit test
        issue(4'd8, 4'd5, 16'h0020);
        chk("R5 bit set", {31'd0, tc_o}, 32'd1);
        issue(4'd8, 4'd4, 16'h0020);
        chk("R5 bit clear", {31'd0, tc_o}, 32'd0);
        issue(4'd8, 4'd15, 16'h8000);
        chk("R5 top bit", {31'd0, tc_o}, 32'd1);

        // R6 compare
        aux_i = 16'd5; ref_i = 16'd9;
        issue(4'd9, 4'd0, 16'd0); chk("R6 eq false", {31'd0, tc_o}, 32'd0);
        issue(4'd9, 4'd1, 16'd0); chk("R6 lt true", {31'd0, tc_o}, 32'd1);
        issue(4'd9, 4'd2, 16'd0); chk("R6 gt false", {31'd0, tc_o}, 32'd0);
        issue(4'd9, 4'd3, 16'd0); chk("R6 ne true", {31'd0, tc_o}, 32'd1);
        aux_i = 16'hFFFF; ref_i = 16'h0001;
        issue(4'd9, 4'd2, 16'd0); chk("R6 gt unsigned", {31'd0, tc_o}, 32'd1);
        aux_i = 16'd7; ref_i = 16'd7;
        issue(4'd9, 4'd0, 16'd0); chk("R6 eq true", {31'd0, tc_o}, 32'd1);

        // R7 normalize check
        load_acc(32'h4000_0000);
        issue(4'd10, 4'd0, 16'd0); chk("R7 bits differ", {31'd0, tc_o}, 32'd1);
        load_acc(32'h2000_0000);
        issue(4'd10, 4'd0, 16'd0); chk("R7 bits equal low", {31'd0, tc_o}, 32'd0);
        load_acc(32'hC000_0000);
        issue(4'd10, 4'd0, 16'd0); chk("R7 bits equal high", {31'd0, tc_o}, 32'd0);

        // R9 R11 individual bits
        issue(4'd2, 4'd2, 16'd0);
        chk("R11 pin cleared", {31'd0, xf_o}, 32'd0);
        issue(4'd1, 4'd2, 16'd0);
        chk("R11 pin set", {31'd0, xf_o}, 32'd1);
        issue(4'd1, 4'd0, 16'd0);
        chk("R9 ovm set", {31'd0, ovm_o}, 32'd1);
        issue(4'd2, 4'd1, 16'd0);
        chk("R9 sxm clear", {31'd0, sxm_o}, 32'd0);
        issue(4'd1, 4'd3, 16'd0);
        chk("R9 selector 3 set ignored", {26'd0, xf_o, tc_o, sxm_o, pm_o, ovm_o}, 32'h21);
        issue(4'd2, 4'd3, 16'd0);
        chk("R9 selector 3 clear ignored", {26'd0, xf_o, tc_o, sxm_o, pm_o, ovm_o}, 32'h21);

        // R10 scale mode write and whole-word load
        issue(4'd3, 4'd2, 16'd0);
        chk("R10 set mode", {30'd0, pm_o}, 32'd2);
        issue(4'd4, 4'd0, 16'h002D);
        chk("R10 load word A", {26'd0, xf_o, tc_o, sxm_o, pm_o, ovm_o}, 32'h2D);
        issue(4'd4, 4'd0, 16'hFF12);
        chk("R10 load word B", {26'd0, xf_o, tc_o, sxm_o, pm_o, ovm_o}, 32'h12);
        chk("R11 pin after load", {31'd0, xf_o}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule